// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Sequencer

This block runs a built-in self-test on a one-bit-wide, single-port synchronous RAM of 2**ADDR_W words. After a start pulse it walks a selected march algorithm element by element. Each element is an ordered list of reads and writes, applied in full to one cell before the address moves on, with the addresses visited in ascending or descending order. The element lists and directions come from a small table inside the block, chosen by a select code.

Every read has a fixed expected bit, and the returned data is compared inline. The first mismatch is latched as the failing address and the element index. The sequence still runs to its end before done is raised. A select code with no algorithm behind it ends the test at once with fail set. The block is meant to sit next to an embedded memory, with its address, write-enable and write-data outputs multiplexed onto the RAM during test.

Top module: `mbist_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, done, fail and mem_we are 0, and fail_addr and fail_elem are 0.
- R2: Select codes pick algorithms, with element 0 always an ascending write of 0: code 0 = {w0; up(r0,w1); down(r1,w0)}; code 1 = {w0; up(r0,w1); down(r1,w0,r0)}; code 2 = {w0; up(r0,w1); down(r1,w0); up(r0)}; code 3 = {w0; up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0)}.
- R3: Within an element, all listed operations are applied to one address before the address steps by one in that element's direction. Up runs from 0 to 2**ADDR_W-1 and down runs the reverse.
- R4: The RAM returns read data one cycle after the read appears on the ports. That bit is compared with the expected value, and any mismatch sets fail.
- R5: fail_addr and fail_elem hold the address and the 0-based element index of the first mismatch of a run. Later mismatches leave them unchanged.
- R6: A run of T operations (T = 5n, 6n, 6n, 10n for codes 0 to 3, where n is the word count) makes one operation per cycle, with 3n, 3n, 3n and 5n of them writes. It continues after a failure, and done rises on the (T+2)-th rising edge after the edge that samples start.
- R7: A start with a select code of 4 or more raises done and fail on the sampling edge itself, with no RAM write and fail_addr = fail_elem = 0.
- R8: A start while idle or done clears done, fail, fail_addr and fail_elem before the new run.
- R9: Once raised, done holds, and mem_we stays 0, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a test |
| alg_sel | input | SEL_W | Algorithm select code |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 1 | RAM write data (expected bit during reads) |
| mem_rdata | input | 1 | RAM read data, one cycle after the read |
| done | output | 1 | Test complete |
| fail | output | 1 | At least one read mismatched |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |

## Verification
The bench builds the block with ADDR_W = 4, so a 16-word RAM model sits behind it and every run is short. That small size lets each of the four algorithms be run with a stuck-at-0 and a stuck-at-1 cell at every one of the 16 addresses. A pair of stuck cells shows the visiting order of the third element, since the ascending and descending algorithms then report different first addresses. Fault-free runs check the exact operation counts and done latency, and all four unsupported codes are tried.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int ELEM_W   = 3;
  localparam int OPI_W    = 2;
  localparam int N_OPS    = 1 << OPI_W;
  localparam int N_ELEMS  = 1 << ELEM_W;
  localparam int N_ALGS   = 4;

  // One RAM operation: rd=1 read expecting val, rd=0 write val
  typedef struct packed {
    logic rd;
    logic val;
  } mop_t;

  typedef struct packed {
    logic [OPI_W-1:0] last;
    mop_t [N_OPS-1:0] ops;
  } melem_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_DONE
  } mstate_t;

  localparam mop_t OP_R0 = '{rd: 1'b1, val: 1'b0};
  localparam mop_t OP_R1 = '{rd: 1'b1, val: 1'b1};
  localparam mop_t OP_W0 = '{rd: 1'b0, val: 1'b0};
  localparam mop_t OP_W1 = '{rd: 1'b0, val: 1'b1};

endpackage

// File: rtl/mbist_alg_rom.sv
module mbist_alg_rom
  import mbist_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [ELEM_W-1:0]  idx,
  output melem_t             elem,
  output logic [N_ELEMS-1:0] dir_vec,
  output logic [ELEM_W-1:0]  last_idx,
  output logic               known
);

  function automatic melem_t mk(input int n, input mop_t a, input mop_t b, input mop_t c);
    melem_t m;
    m        = '0;
    m.last   = OPI_W'(n - 1);
    m.ops[0] = a;
    m.ops[1] = b;
    m.ops[2] = c;
    return m;
  endfunction

  always_comb begin
    elem     = '0;
    dir_vec  = '0;
    last_idx = '0;
    known    = 1'b1;
    case (int'(sel))
      0: begin
        last_idx = ELEM_W'(2);
        dir_vec  = N_ELEMS'(8'b0000_0100);
        case (int'(idx))
          0:       elem = mk(1, OP_W0, OP_W0, OP_W0);
          1:       elem = mk(2, OP_R0, OP_W1, OP_W0);
          2:       elem = mk(2, OP_R1, OP_W0, OP_W0);
          default: elem = '0;
        endcase
      end
      1: begin
        last_idx = ELEM_W'(2);
        dir_vec  = N_ELEMS'(8'b0000_0100);
        case (int'(idx))
          0:       elem = mk(1, OP_W0, OP_W0, OP_W0);
          1:       elem = mk(2, OP_R0, OP_W1, OP_W0);
          2:       elem = mk(3, OP_R1, OP_W0, OP_R0);
          default: elem = '0;
        endcase
      end
      2: begin
        last_idx = ELEM_W'(3);
        dir_vec  = N_ELEMS'(8'b0000_0100);
        case (int'(idx))
          0:       elem = mk(1, OP_W0, OP_W0, OP_W0);
          1:       elem = mk(2, OP_R0, OP_W1, OP_W0);
          2:       elem = mk(2, OP_R1, OP_W0, OP_W0);
          3:       elem = mk(1, OP_R0, OP_R0, OP_R0);
          default: elem = '0;
        endcase
      end
      3: begin
        last_idx = ELEM_W'(5);
        dir_vec  = N_ELEMS'(8'b0001_1000);
        case (int'(idx))
          0:       elem = mk(1, OP_W0, OP_W0, OP_W0);
          1:       elem = mk(2, OP_R0, OP_W1, OP_W0);
          2:       elem = mk(2, OP_R1, OP_W0, OP_W0);
          3:       elem = mk(2, OP_R0, OP_W1, OP_W0);
          4:       elem = mk(2, OP_R1, OP_W0, OP_W0);
          5:       elem = mk(1, OP_R0, OP_R0, OP_R0);
          default: elem = '0;
        endcase
      end
      default: known = 1'b0;
    endcase
  end

endmodule

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_down,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic down_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      down_q <= load_down;
      addr   <= load_down ? TOP_ADDR : '0;
    end else if (step) begin
      addr <= down_q ? addr - 1'b1 : addr + 1'b1;
    end
  end

  assign at_end = down_q ? (addr == '0) : (addr == TOP_ADDR);

endmodule

// File: rtl/mbist_resp_chk.sv
module mbist_resp_chk
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              force_fail,
  input  logic              iss_rd,
  input  logic              iss_exp,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [ELEM_W-1:0] iss_elem,
  input  logic              rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ELEM_W-1:0] fail_elem
);

  logic              p_rd;
  logic              p_exp;
  logic [ADDR_W-1:0] p_addr;
  logic [ELEM_W-1:0] p_elem;

  // Align the issued read with the RAM's one-cycle output latency
  always_ff @(posedge clk) begin
    if (rst) begin
      p_rd   <= 1'b0;
      p_exp  <= 1'b0;
      p_addr <= '0;
      p_elem <= '0;
    end else begin
      p_rd   <= iss_rd;
      p_exp  <= iss_exp;
      p_addr <= iss_addr;
      p_elem <= iss_elem;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (clr) begin
      fail      <= force_fail;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (p_rd && (rdata != p_exp) && !fail) begin
      fail      <= 1'b1;
      fail_addr <= p_addr;
      fail_elem <= p_elem;
    end
  end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  alg_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_wdata,
  input  logic              mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ELEM_W-1:0] fail_elem
);

  mstate_t           st_q;
  logic [ELEM_W-1:0] elem_q;
  logic [ELEM_W-1:0] elem_nxt;
  logic [OPI_W-1:0]  opi_q;
  logic              flush_q;
  logic              done_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic              mem_we_q;
  logic              mem_wdata_q;
  logic              rd_q;
  logic [ELEM_W-1:0] elem_tag_q;

  melem_t             cur_elem;
  mop_t               cur_op;
  logic [N_ELEMS-1:0] dir_vec;
  logic [ELEM_W-1:0]  last_idx;
  logic               known;

  logic [ADDR_W-1:0] seq_addr;
  logic              seq_end;
  logic              seq_load;
  logic              seq_load_down;
  logic              seq_step;

  logic idle_like;
  logic begin_req;
  logic op_last;
  logic elem_last;
  logic busy;

  mbist_alg_rom #(.SEL_W(SEL_W)) u_rom (
    .sel      (alg_sel),
    .idx      (elem_q),
    .elem     (cur_elem),
    .dir_vec  (dir_vec),
    .last_idx (last_idx),
    .known    (known)
  );

  assign cur_op    = cur_elem.ops[opi_q];
  assign elem_nxt  = elem_q + 1'b1;
  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign begin_req = idle_like && start;
  assign op_last   = (opi_q == cur_elem.last);
  assign elem_last = (elem_q == last_idx);
  assign busy      = (st_q == ST_RUN) || (st_q == ST_FLUSH);

  // Address sequencer control: element 0 always ascends
  always_comb begin
    seq_load      = 1'b0;
    seq_load_down = 1'b0;
    seq_step      = 1'b0;
    if (begin_req) begin
      seq_load = 1'b1;
    end else if (st_q == ST_RUN && op_last) begin
      if (!seq_end) begin
        seq_step = 1'b1;
      end else if (!elem_last) begin
        seq_load      = 1'b1;
        seq_load_down = dir_vec[elem_nxt];
      end
    end
  end

  mbist_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (seq_load),
    .load_down (seq_load_down),
    .step      (seq_step),
    .addr      (seq_addr),
    .at_end    (seq_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      elem_q      <= '0;
      opi_q       <= '0;
      flush_q     <= 1'b0;
      done_q      <= 1'b0;
      mem_addr_q  <= '0;
      mem_we_q    <= 1'b0;
      mem_wdata_q <= 1'b0;
      rd_q        <= 1'b0;
      elem_tag_q  <= '0;
    end else begin
      mem_we_q <= 1'b0;
      rd_q     <= 1'b0;
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            elem_q <= '0;
            opi_q  <= '0;
            if (known) begin
              st_q   <= ST_RUN;
              done_q <= 1'b0;
            end else begin
              st_q   <= ST_DONE;
              done_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          mem_addr_q  <= seq_addr;
          mem_we_q    <= !cur_op.rd;
          mem_wdata_q <= cur_op.val;
          rd_q        <= cur_op.rd;
          elem_tag_q  <= elem_q;
          if (!op_last) begin
            opi_q <= opi_q + 1'b1;
          end else begin
            opi_q <= '0;
            if (seq_end) begin
              if (elem_last) begin
                st_q    <= ST_FLUSH;
                flush_q <= 1'b0;
              end else begin
                elem_q <= elem_nxt;
              end
            end
          end
        end
        ST_FLUSH: begin
          flush_q <= 1'b1;
          if (flush_q) begin
            st_q    <= ST_DONE;
            done_q  <= 1'b1;
            flush_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  mbist_resp_chk #(.ADDR_W(ADDR_W)) u_chk_resp (
    .clk        (clk),
    .rst        (rst),
    .clr        (begin_req),
    .force_fail (!known),
    .iss_rd     (rd_q),
    .iss_exp    (mem_wdata_q),
    .iss_addr   (mem_addr_q),
    .iss_elem   (elem_tag_q),
    .rdata      (mem_rdata),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .fail_elem  (fail_elem)
  );

  assign mem_addr  = mem_addr_q;
  assign mem_we    = mem_we_q;
  assign mem_wdata = mem_wdata_q;
  assign done      = done_q;

endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [SEL_W-1:0]  alg_sel,
  input logic              mem_we,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [ELEM_W-1:0] fail_elem,
  input logic              busy
);

  // R4: a new failure traces back to a read on the ports two cycles before
  p_fail_from_read_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(fail) && $past(busy)) |-> $past(!mem_we, 2));

  // R5: first failure record is frozen until the next start
  p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_elem)));

  // R7: unsupported code ends the test on the sampling edge
  p_bad_sel_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && int'(alg_sel) > 3) |=> (done && fail && !mem_we));

  // R8: a supported start clears the result flags
  p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && int'(alg_sel) <= 3) |=> (!done && !fail && fail_addr == '0));

  // R9: done holds until start
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R9: no writes outside a run
  p_no_write_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we);

endmodule

bind mbist_ctrl mbist_ctrl_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .alg_sel   (alg_sel),
  .mem_we    (mem_we),
  .done      (done),
  .fail      (fail),
  .fail_addr (fail_addr),
  .fail_elem (fail_elem),
  .busy      (busy)
);

// File: tb/mbist_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbist_ctrl_tb_top;

  localparam int AW = 4;
  localparam int SW = 3;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [SW-1:0] alg_sel = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic          mem_wdata;
  logic          mem_rdata;
  logic          done;
  logic          fail;
  logic [AW-1:0] fail_addr;
  logic [2:0]    fail_elem;

  int checks = 0;
  int errors = 0;

  // Fault injection: two stuck cells
  logic          fa_en = 1'b0, fb_en = 1'b0;
  logic [AW-1:0] fa_addr = '0, fb_addr = '0;
  logic          fa_val = 1'b0, fb_val = 1'b0;
  logic          ram_q [0:NW-1];

  always #4 clk = ~clk;

  function automatic logic cell_view(input logic [AW-1:0] a);
    if (fa_en && a == fa_addr) return fa_val;
    if (fb_en && a == fb_addr) return fb_val;
    return ram_q[a];
  endfunction

  always @(posedge clk) begin
    if (mem_we) ram_q[mem_addr] <= mem_wdata;
    mem_rdata <= cell_view(mem_addr);
  end

  mbist_ctrl #(.ADDR_W(AW), .SEL_W(SW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .alg_sel   (alg_sel),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_alg(input int alg, input int exp_fail, input int exp_addr,
                         input int exp_elem, input string what);
    int k = 0;
    int wr = 0;
    int t_ops, t_wr;
    case (alg)
      0:       begin t_ops = 5 * NW;  t_wr = 3 * NW; end
      1:       begin t_ops = 6 * NW;  t_wr = 3 * NW; end
      2:       begin t_ops = 6 * NW;  t_wr = 3 * NW; end
      default: begin t_ops = 10 * NW; t_wr = 5 * NW; end
    endcase
    @(negedge clk);
    alg_sel = SW'(alg);
    start   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk({"R8 done cleared ", what}, done, 0);
    chk({"R8 fail cleared ", what}, fail, 0);
    while (!done && k < 4000) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (mem_we) wr++;
    end
    chk({"R6 done latency ", what}, k, t_ops + 2);
    chk({"R6 write count ", what}, wr, t_wr);
    chk({"R4 fail flag ", what}, fail, exp_fail);
    chk({"R5 fail_addr ", what}, fail_addr, exp_fail ? exp_addr : 0);
    chk({"R5 fail_elem ", what}, fail_elem, exp_fail ? exp_elem : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 done in reset", done, 0);
    chk("R1 we in reset", mem_we, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 fail_addr", fail_addr, 0);
    chk("R1 fail_elem", fail_elem, 0);

    for (int alg = 0; alg < 4; alg++) begin
      // R2 fault-free run passes with full operation counts
      fa_en = 1'b0; fb_en = 1'b0;
      run_alg(alg, 0, 0, 0, $sformatf("R2 clean alg%0d", alg));
      repeat (3) @(negedge clk);
      chk("R9 done holds", done, 1);
      chk("R9 no write when done", mem_we, 0);

      for (int a = 0; a < NW; a++) begin
        // Stuck at 1: first read of 0 in element 1 fails
        fa_en = 1'b1; fa_addr = AW'(a); fa_val = 1'b1;
        run_alg(alg, 1, a, 1, $sformatf("R4 sa1 alg%0d addr%0d", alg, a));
        // Stuck at 0: first read of 1 in element 2 fails
        fa_val = 1'b0;
        run_alg(alg, 1, a, 2, $sformatf("R4 sa0 alg%0d addr%0d", alg, a));
      end

      // R3: two stuck-0 cells; element 2 direction decides which is first
      fa_en = 1'b1; fa_addr = AW'(3);  fa_val = 1'b0;
      fb_en = 1'b1; fb_addr = AW'(12); fb_val = 1'b0;
      run_alg(alg, 1, (alg == 3) ? 3 : 12, 2, $sformatf("R3 order alg%0d", alg));

      // R5: earlier failure in element 1 wins over a later one
      fa_addr = AW'(5); fa_val = 1'b1;
      fb_addr = AW'(2); fb_val = 1'b0;
      run_alg(alg, 1, 5, 1, $sformatf("R5 first kept alg%0d", alg));
      fa_en = 1'b0; fb_en = 1'b0;
    end

    // R7: unsupported codes
    for (int s = 4; s < 8; s++) begin
      int wr = 0;
      @(negedge clk);
      alg_sel = SW'(s);
      start   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R7 done at once", done, 1);
      chk("R7 fail at once", fail, 1);
      chk("R7 fail_addr zero", fail_addr, 0);
      chk("R7 fail_elem zero", fail_elem, 0);
      for (int c = 0; c < 4; c++) begin
        if (mem_we) wr++;
        @(negedge clk);
      end
      chk("R7 no writes", wr, 0);
      chk("R9 done holds after bad code", done, 1);
    end

    // R8: restart after a failing result clears it
    run_alg(0, 0, 0, 0, "R8 restart clean");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule